// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers five interrupt sources into one status byte and raises a single request line toward a host processor while any status bit is set. Three sources are levels that the block copies each cycle: a real-time clock, a serial port and a disk controller. Two are single-cycle strobes that latch a bit until it is acknowledged: a coprocessor doorbell and a once-per-frame vertical blank tick.

When the host runs an acknowledge cycle, the block picks the most urgent pending source among the disk controller, the coprocessor and vertical blank, in that order. It returns that source's 8-bit vector and clears the bit if that source clears on acknowledge. The disk controller bit is never cleared by acknowledge; it falls only when its source line drops. The clock and serial-port bits take no part in acknowledge. An acknowledge that finds none of the three handled sources pending returns vector 0 and pulses an error flag.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the status byte, request line, vector, vector-valid strobe and error flag are all zero.
- R2: Status bit positions are fixed: clock = bit 1, serial port = bit 2, coprocessor = bit 4, vertical blank = bit 5, disk controller = bit 7. Bits 0, 3 and 6 read as zero.
- R3: The clock, serial-port and disk-controller bits equal the level of their input as sampled at the previous clock edge, rising and falling with it.
- R4: A one-cycle strobe on the coprocessor or vertical-blank input sets its bit, and the bit stays set until an acknowledge clears it.
- R5: The request line is high exactly while at least one status bit is set.
- R6: Acknowledge priority is disk controller, then coprocessor, then vertical blank. The clock and serial-port bits are not considered.
- R7: The vector-valid strobe is high for exactly the one cycle after an acknowledge. The vector is 11 for the disk controller, 12 for the coprocessor and 13 for vertical blank.
- R8: An acknowledge of the coprocessor or vertical blank clears only that bit. An acknowledge of the disk controller clears no bit.
- R9: An acknowledge with none of bits 7, 5 and 4 set returns vector 0, pulses the error flag with the valid strobe, and leaves the status byte unchanged.
- R10: If a coprocessor strobe and an acknowledge that would clear the coprocessor bit fall in the same cycle, the bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_lvl_i | input | 1 | Real-time clock request level |
| uart_lvl_i | input | 1 | Serial-port request level |
| scsi_lvl_i | input | 1 | Disk-controller request level |
| dsp_set_i | input | 1 | Coprocessor doorbell strobe |
| vbl_set_i | input | 1 | Vertical-blank strobe |
| ack_i | input | 1 | Host acknowledge strobe, one cycle |
| irq_o | output | 1 | Interrupt request to the host |
| status_o | output | 8 | Pending status byte |
| vec_valid_o | output | 1 | Vector valid, one cycle after acknowledge |
| vec_o | output | 8 | Vector of the acknowledged source, held until the next acknowledge |
| ack_err_o | output | 1 | Unhandled-acknowledge flag, coincident with vector valid |

## Verification
Each stimulus is applied on a falling edge. Results are read on the next falling edge, one full cycle later. By then the single register stage has captured the new level or strobe, and the request line has followed from it combinationally. The vector, valid strobe and error flag come from a register clocked on the acknowledge edge, so the scoreboard expects them at that same falling edge. The bench then checks that the strobe has dropped one cycle later. Status bytes after an acknowledge are read at the same point, which shows the clear, or its absence, in the cycle after the acknowledge.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;

   // Outcome of the priority search over the acknowledge-handled bits
   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_VBL  = 2'd1,
      HIT_DSP  = 2'd2,
      HIT_SCSI = 2'd3
   } hit_e;

   // Kind of storage a status bit uses
   typedef enum logic [1:0] {
      BIT_UNUSED = 2'd0,
      BIT_LEVEL  = 2'd1,
      BIT_STICKY = 2'd2
   } bit_kind_e;

   function automatic int count_ones32(input logic [31:0] v);
      int n;
      n = 0;
      for (int k = 0; k < 32; k++) n += int'(v[k]);
      return n;
   endfunction

endpackage

// File: rtl/vec_irq_status_reg.sv
module vec_irq_status_reg #(
   parameter int                STAT_W      = 8,
   parameter logic [STAT_W-1:0] LEVEL_MASK  = '0,
   parameter logic [STAT_W-1:0] STICKY_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] req_i,
   input  logic [STAT_W-1:0] clr_i,
   output logic [STAT_W-1:0] status_o
);
   import vec_irq_pkg::*;

   for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      localparam bit_kind_e KIND = LEVEL_MASK[i]  ? BIT_LEVEL  :
                                   STICKY_MASK[i] ? BIT_STICKY : BIT_UNUSED;
      if (KIND == BIT_LEVEL) begin : g_level
         // copies its source; acknowledge has no say
         logic unused_clr;
         assign unused_clr = clr_i[i];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status_o[i] <= 1'b0;
            else        status_o[i] <= req_i[i];
         end
      end else if (KIND == BIT_STICKY) begin : g_sticky
         // set beats clear so a strobe in the acknowledge cycle survives
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status_o[i] <= 1'b0;
            else        status_o[i] <= req_i[i] | (status_o[i] & ~clr_i[i]);
         end
      end else begin : g_unused
         logic unused_in;
         assign unused_in   = req_i[i] | clr_i[i];
         assign status_o[i] = 1'b0;
      end
   end

endmodule

// File: rtl/vec_irq_prio.sv
module vec_irq_prio #(
   parameter int STAT_W   = 8,
   parameter int SCSI_BIT = 7,
   parameter int DSP_BIT  = 4,
   parameter int VBL_BIT  = 5
) (
   input  logic [STAT_W-1:0]  status_i,
   output vec_irq_pkg::hit_e  hit_o
);
   import vec_irq_pkg::*;

   localparam logic [STAT_W-1:0] ONE       = STAT_W'(1);
   localparam logic [STAT_W-1:0] USED_MASK = (ONE << SCSI_BIT) | (ONE << DSP_BIT) | (ONE << VBL_BIT);

   logic unused_rest;
   assign unused_rest = |(status_i & ~USED_MASK);

   always_comb begin
      if (status_i[SCSI_BIT])     hit_o = HIT_SCSI;
      else if (status_i[DSP_BIT]) hit_o = HIT_DSP;
      else if (status_i[VBL_BIT]) hit_o = HIT_VBL;
      else                        hit_o = HIT_NONE;
   end

endmodule

// File: rtl/vec_irq_vector.sv
module vec_irq_vector #(
   parameter int VEC_W    = 8,
   parameter int VEC_SCSI = 11,
   parameter int VEC_DSP  = 12,
   parameter int VEC_VBL  = 13,
   parameter int VEC_NONE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack_i,
   input  vec_irq_pkg::hit_e hit_i,
   output logic [VEC_W-1:0]  vec_o,
   output logic              valid_o,
   output logic              err_o
);
   import vec_irq_pkg::*;

   logic [VEC_W-1:0] vec_next;

   always_comb begin
      unique case (hit_i)
         HIT_SCSI: vec_next = VEC_W'(VEC_SCSI);
         HIT_DSP:  vec_next = VEC_W'(VEC_DSP);
         HIT_VBL:  vec_next = VEC_W'(VEC_VBL);
         default:  vec_next = VEC_W'(VEC_NONE);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_o   <= '0;
         valid_o <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         valid_o <= ack_i;
         err_o   <= ack_i && (hit_i == HIT_NONE);
         if (ack_i) vec_o <= vec_next;
      end
   end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
   parameter int STAT_W   = 8,
   parameter int VEC_W    = 8,
   parameter int RTC_BIT  = 1,
   parameter int UART_BIT = 2,
   parameter int DSP_BIT  = 4,
   parameter int VBL_BIT  = 5,
   parameter int SCSI_BIT = 7,
   parameter int VEC_SCSI = 11,
   parameter int VEC_DSP  = 12,
   parameter int VEC_VBL  = 13,
   parameter int VEC_NONE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rtc_lvl_i,
   input  logic              uart_lvl_i,
   input  logic              scsi_lvl_i,
   input  logic              dsp_set_i,
   input  logic              vbl_set_i,
   input  logic              ack_i,
   output logic              irq_o,
   output logic [STAT_W-1:0] status_o,
   output logic              vec_valid_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic              ack_err_o
);
   import vec_irq_pkg::*;

   localparam logic [STAT_W-1:0] ONE         = STAT_W'(1);
   localparam logic [STAT_W-1:0] LEVEL_MASK  = (ONE << RTC_BIT) | (ONE << UART_BIT) | (ONE << SCSI_BIT);
   localparam logic [STAT_W-1:0] STICKY_MASK = (ONE << DSP_BIT) | (ONE << VBL_BIT);
   localparam int                VEC_LIMIT   = 1 << VEC_W;

   // elaboration-time parameter checks
   if (STAT_W < 1 || STAT_W > 32) begin : g_bad_stat_w
      $error("STAT_W must lie in 1..32");
   end
   if (VEC_W < 1 || VEC_W > 16) begin : g_bad_vec_w
      $error("VEC_W must lie in 1..16");
   end
   if (RTC_BIT >= STAT_W || UART_BIT >= STAT_W || DSP_BIT >= STAT_W ||
       VBL_BIT >= STAT_W || SCSI_BIT >= STAT_W) begin : g_bad_pos
      $error("a source bit position lies outside the status register");
   end
   if (count_ones32(32'(LEVEL_MASK | STICKY_MASK)) != 5 ||
       (LEVEL_MASK & STICKY_MASK) != '0) begin : g_bad_overlap
      $error("source bit positions must be distinct");
   end
   if (VEC_SCSI >= VEC_LIMIT || VEC_DSP >= VEC_LIMIT ||
       VEC_VBL >= VEC_LIMIT || VEC_NONE >= VEC_LIMIT) begin : g_bad_vec
      $error("a vector value does not fit in VEC_W bits");
   end

   logic [STAT_W-1:0] req;
   logic [STAT_W-1:0] clr;
   hit_e              hit;

   always_comb begin
      req           = '0;
      req[RTC_BIT]  = rtc_lvl_i;
      req[UART_BIT] = uart_lvl_i;
      req[SCSI_BIT] = scsi_lvl_i;
      req[DSP_BIT]  = dsp_set_i;
      req[VBL_BIT]  = vbl_set_i;
   end

   always_comb begin
      clr = '0;
      if (ack_i) begin
         unique case (hit)
            HIT_DSP: clr[DSP_BIT] = 1'b1;
            HIT_VBL: clr[VBL_BIT] = 1'b1;
            default: clr = '0;
         endcase
      end
   end

   vec_irq_status_reg #(
      .STAT_W      (STAT_W),
      .LEVEL_MASK  (LEVEL_MASK),
      .STICKY_MASK (STICKY_MASK)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req),
      .clr_i    (clr),
      .status_o (status_o)
   );

   vec_irq_prio #(
      .STAT_W   (STAT_W),
      .SCSI_BIT (SCSI_BIT),
      .DSP_BIT  (DSP_BIT),
      .VBL_BIT  (VBL_BIT)
   ) u_prio (
      .status_i (status_o),
      .hit_o    (hit)
   );

   vec_irq_vector #(
      .VEC_W    (VEC_W),
      .VEC_SCSI (VEC_SCSI),
      .VEC_DSP  (VEC_DSP),
      .VEC_VBL  (VEC_VBL),
      .VEC_NONE (VEC_NONE)
   ) u_vector (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack_i   (ack_i),
      .hit_i   (hit),
      .vec_o   (vec_o),
      .valid_o (vec_valid_o),
      .err_o   (ack_err_o)
   );

   assign irq_o = |status_o;

endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
   parameter int STAT_W   = 8,
   parameter int VEC_W    = 8,
   parameter int RTC_BIT  = 1,
   parameter int DSP_BIT  = 4,
   parameter int VBL_BIT  = 5,
   parameter int SCSI_BIT = 7,
   parameter int VEC_SCSI = 11,
   parameter int VEC_NONE = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rtc_lvl_i,
   input logic              dsp_set_i,
   input logic              vbl_set_i,
   input logic              ack_i,
   input logic [STAT_W-1:0] status_o,
   input logic              vec_valid_o,
   input logic [VEC_W-1:0]  vec_o,
   input logic              ack_err_o
);

   // R3
   rtc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (status_o[RTC_BIT] == $past(rtc_lvl_i)));

   // R4
   dsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[DSP_BIT] && !ack_i) |=> status_o[DSP_BIT]);

   // R4
   vbl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vbl_set_i |=> status_o[VBL_BIT]);

   // R6
   scsi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && status_o[SCSI_BIT]) |=> (vec_o == VEC_W'(VEC_SCSI)));

   // R7
   ack_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> vec_valid_o);

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_i |=> !vec_valid_o);

   // R9
   unhandled_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !status_o[SCSI_BIT] && !status_o[DSP_BIT] && !status_o[VBL_BIT])
      |=> (ack_err_o && vec_o == VEC_W'(VEC_NONE)));

   // R9
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && status_o[DSP_BIT]) |=> !ack_err_o);

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_set_i |=> status_o[DSP_BIT]);

endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
   .STAT_W   (STAT_W),
   .VEC_W    (VEC_W),
   .RTC_BIT  (RTC_BIT),
   .DSP_BIT  (DSP_BIT),
   .VBL_BIT  (VBL_BIT),
   .SCSI_BIT (SCSI_BIT),
   .VEC_SCSI (VEC_SCSI),
   .VEC_NONE (VEC_NONE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rtc_lvl_i   (rtc_lvl_i),
   .dsp_set_i   (dsp_set_i),
   .vbl_set_i   (vbl_set_i),
   .ack_i       (ack_i),
   .status_o    (status_o),
   .vec_valid_o (vec_valid_o),
   .vec_o       (vec_o),
   .ack_err_o   (ack_err_o)
);

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       rtc_lvl_i, uart_lvl_i, scsi_lvl_i, dsp_set_i, vbl_set_i, ack_i;
   logic       irq_o;
   logic [7:0] status_o;
   logic       vec_valid_o;
   logic [7:0] vec_o;
   logic       ack_err_o;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;

   logic [8:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_irq_ctrl u_vec_irq_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .rtc_lvl_i   (rtc_lvl_i),
      .uart_lvl_i  (uart_lvl_i),
      .scsi_lvl_i  (scsi_lvl_i),
      .dsp_set_i   (dsp_set_i),
      .vbl_set_i   (vbl_set_i),
      .ack_i       (ack_i),
      .irq_o       (irq_o),
      .status_o    (status_o),
      .vec_valid_o (vec_valid_o),
      .vec_o       (vec_o),
      .ack_err_o   (ack_err_o)
   );

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // driver: issue an acknowledge and push its expected result
   task automatic do_ack(input logic [7:0] exp_vec, input logic exp_err, input string tag, input logic with_dsp);
      exp_q.push_back({exp_err, exp_vec});
      tag_q.push_back(tag);
      ack_i     = 1'b1;
      dsp_set_i = with_dsp;
      @(negedge clk);
      ack_i     = 1'b0;
      dsp_set_i = 1'b0;
   endtask

   // monitor: compare each vector as the design presents it
   always @(negedge clk) begin
      if (rst_n === 1'b1 && vec_valid_o === 1'b1) begin
         if (exp_q.size() == 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL R7 unexpected valid strobe: actual=1 expected=0");
         end else begin
            logic [8:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, "vector", vec_o, e[7:0]);
            chk(t, "error flag", {7'd0, ack_err_o}, {7'd0, e[8]});
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      rtc_lvl_i = 0; uart_lvl_i = 0; scsi_lvl_i = 0;
      dsp_set_i = 0; vbl_set_i = 0; ack_i = 0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1", "status", status_o, 8'h00);
      chk("R1", "irq", {7'd0, irq_o}, 8'h00);
      chk("R1", "valid", {7'd0, vec_valid_o}, 8'h00);
      chk("R1", "vector", vec_o, 8'h00);
      chk("R1", "error", {7'd0, ack_err_o}, 8'h00);

      // R3 / R5 clock level, then unhandled acknowledge R9
      rtc_lvl_i = 1; tick();
      chk("R3", "status rtc", status_o, 8'h02);
      chk("R5", "irq on", {7'd0, irq_o}, 8'h01);
      do_ack(8'h00, 1'b1, "R9", 1'b0);
      chk("R9", "status untouched", status_o, 8'h02);
      tick();
      chk("R7", "valid drops", {7'd0, vec_valid_o}, 8'h00);
      chk("R9", "error drops", {7'd0, ack_err_o}, 8'h00);
      rtc_lvl_i = 0; tick();
      chk("R3", "status rtc fall", status_o, 8'h00);
      chk("R5", "irq off", {7'd0, irq_o}, 8'h00);

      // R2 serial port position, unhandled acknowledge keeps it
      uart_lvl_i = 1; tick();
      chk("R2", "status uart", status_o, 8'h04);
      do_ack(8'h00, 1'b1, "R9", 1'b0);
      chk("R9", "uart untouched", status_o, 8'h04);
      uart_lvl_i = 0; tick();
      chk("R3", "status uart fall", status_o, 8'h00);

      // R4 sticky coprocessor bit
      dsp_set_i = 1; tick(); dsp_set_i = 0;
      chk("R4", "dsp set", status_o, 8'h10);
      repeat (3) tick();
      chk("R4", "dsp held", status_o, 8'h10);
      vbl_set_i = 1; tick(); vbl_set_i = 0;
      chk("R2", "dsp+vbl", status_o, 8'h30);
      do_ack(8'd12, 1'b0, "R6", 1'b0);
      chk("R8", "dsp cleared only", status_o, 8'h20);
      do_ack(8'd13, 1'b0, "R7", 1'b0);
      chk("R8", "vbl cleared", status_o, 8'h00);
      chk("R5", "irq idle", {7'd0, irq_o}, 8'h00);

      // disk controller over coprocessor, never cleared by ack
      scsi_lvl_i = 1; dsp_set_i = 1; tick(); dsp_set_i = 0;
      chk("R2", "scsi+dsp", status_o, 8'h90);
      do_ack(8'd11, 1'b0, "R6", 1'b0);
      chk("R8", "scsi kept", status_o, 8'h90);
      scsi_lvl_i = 0; tick();
      chk("R3", "scsi fall", status_o, 8'h10);
      do_ack(8'd12, 1'b0, "R7", 1'b0);
      chk("R8", "dsp cleared", status_o, 8'h00);

      // disk controller over vertical blank
      vbl_set_i = 1; scsi_lvl_i = 1; tick(); vbl_set_i = 0;
      chk("R2", "scsi+vbl", status_o, 8'hA0);
      do_ack(8'd11, 1'b0, "R6", 1'b0);
      chk("R8", "scsi ack clears none", status_o, 8'hA0);
      scsi_lvl_i = 0; tick();
      do_ack(8'd13, 1'b0, "R7", 1'b0);
      chk("R8", "vbl cleared", status_o, 8'h00);

      // R10 set and clear in the same cycle
      dsp_set_i = 1; tick(); dsp_set_i = 0;
      chk("R4", "dsp set again", status_o, 8'h10);
      do_ack(8'd12, 1'b0, "R10", 1'b1);
      chk("R10", "set wins", status_o, 8'h10);
      do_ack(8'd12, 1'b0, "R10", 1'b0);
      chk("R10", "then cleared", status_o, 8'h00);

      tick();
      chk("R7", "all vectors seen", 8'(exp_q.size()), 8'h00);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule